// File: doc/BRIEF.md
# Inverse Square Root Operand Screen

This block sits in front of an iterative inverse-square-root unit for IEEE single-precision values. It takes one operand per cycle and sorts it into one of five classes: NaN, negative nonzero, positive infinity, zero, or an ordinary positive value. The first four classes need no iteration. For them the block produces final replacement words for the operand and for the result, and it raises an invalid pulse where the standard calls for one. An ordinary positive value goes on to the iteration. If its exponent is small, the block first multiplies it exactly by 2^64 so that the iteration keeps full precision, and it reports this with an adjust code that the later rescaling step uses.

The block also supplies the starting estimate for the iteration. It reads an 8-bit seed from a 128-entry table. The table index combines the parity of the adjusted operand's exponent with the top six fraction bits. There is one registered stage: a result appears one cycle after its input is presented with `in_valid`, and it is held until the next valid input.

Top module: `fp_isqrt_prep`

## Requirements
- R1: A NaN input (exponent field 255, fraction nonzero, either sign) drives both `out_operand` and `out_result` to 0xFFFFFFFF, with `out_normal` at 0 and `out_adjust` at 0x00.
- R2: `out_invalid` is 1, in the same cycle as `out_valid`, in two cases. The first is a NaN whose fraction bit 22 is 0 (signaling). The second is a non-NaN input with the sign bit set that is not zero. In every other case, including quiet NaNs and negative zero, it is 0.
- R3: A non-NaN input with sign bit 1 that is not ±0 drives both `out_operand` and `out_result` to 0xFFFFFFFF. This covers negative infinity and negative subnormals.
- R4: Positive infinity (0x7F800000) drives both `out_operand` and `out_result` to 0x7F800000.
- R5: A zero of either sign passes to `out_operand` unchanged. `out_result` becomes 0x3F800000 (1.0), `out_adjust` 0x00 and `out_normal` 0.
- R6: A positive finite nonzero input sets `out_normal` to 1 and `out_result` to 0. If its exponent field (bits 30:23) is 24 or less, `out_operand` is the input times 2^64 and `out_adjust` is 0xE0. If the exponent field is 25 or more, `out_operand` equals the input and `out_adjust` is 0x00.
- R7: A positive subnormal input whose leading one is at fraction bit p scales exactly. It yields exponent field 42+p, and the fraction is the input's fraction bits below p shifted up to the top of the field.
- R8: `out_seed` is table entry {bit 23, bits 22:17} of `out_operand`. Entries 0 to 63 fall without increase from 0x69 to 0x01. Entries 64 to 127 fall from 0xFE to 0x6B. Entry i lies within 1 of 256·(2/√x − 1), where x = 2 + (i+0.5)/32 for the lower half and x = 1 + (i−64+0.5)/64 for the upper half.
- R9: `out_valid` is 1 exactly one cycle after `in_valid` was 1. While no input is presented, the data outputs hold their last value and `out_invalid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| in_operand | input | 32 | Single-precision operand |
| out_valid | output | 1 | Registered outputs updated from a valid input |
| out_operand | output | 32 | Adjusted or replacement operand |
| out_result | output | 32 | Initial result word |
| out_adjust | output | 8 | Prescale code, 0xE0 when scaled by 2^64 |
| out_normal | output | 1 | Operand continues to the iteration |
| out_invalid | output | 1 | Invalid-operation pulse |
| out_seed | output | 8 | Seed estimate for the iteration |

## Verification
The hardest situations to reach are subnormal operands. Each position of the leading one needs its own exponent and fraction result, and the exponent 24/25 edge decides whether scaling happens at all. The stimulus walks the leading one through all 23 fraction positions with sparse and dense patterns below it. It also sweeps every exponent field from 1 to 254 under several fraction patterns. To reach every seed entry, the operands use exponents 126 and 127, which lie above the scaling limit. Their parity and top fraction bits then select each of the 128 indices directly, and each seed is compared with the arithmetic estimate in the bench.

// File: rtl/isqrt_prep_pkg.sv
package isqrt_prep_pkg;
  localparam int FP_W     = 32;
  localparam int EXP_W    = 8;
  localparam int FRAC_W   = 23;
  localparam int SEED_W   = 8;
  localparam int SEED_IDX_W = 7;
  localparam int FRAC_IDX_W = SEED_IDX_W - 1;
  localparam int POS_W    = $clog2(FRAC_W);

  localparam logic [EXP_W-1:0] EXP_ALL = '1;
  localparam logic [FP_W-1:0]  WORD_NAN = '1;
  localparam logic [FP_W-1:0]  WORD_PINF = {1'b0, EXP_ALL, {FRAC_W{1'b0}}};
  localparam logic [FP_W-1:0]  WORD_ONE  = 32'h3F80_0000;

  typedef enum logic [2:0] {
    CLS_NAN,
    CLS_NEG,
    CLS_PINF,
    CLS_ZERO,
    CLS_NORM
  } isqrt_cls_e;
endpackage

// File: rtl/isqrt_screen.sv
module isqrt_screen
  import isqrt_prep_pkg::*;
(
  input  logic [FP_W-1:0] op_i,
  output isqrt_cls_e      cls_o,
  output logic            invalid_o
);
  logic             sign_b;
  logic [EXP_W-1:0] exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign sign_b = op_i[FP_W-1];
  assign exp_f  = op_i[FP_W-2 -: EXP_W];
  assign frac_f = op_i[FRAC_W-1:0];

  // Priority: NaN first, then zero of any sign, then any negative value.
  always_comb begin
    invalid_o = 1'b0;
    if (exp_f == EXP_ALL && frac_f != '0) begin
      cls_o     = CLS_NAN;
      invalid_o = ~frac_f[FRAC_W-1];
    end else if (exp_f == '0 && frac_f == '0) begin
      cls_o = CLS_ZERO;
    end else if (sign_b) begin
      cls_o     = CLS_NEG;
      invalid_o = 1'b1;
    end else if (exp_f == EXP_ALL) begin
      cls_o = CLS_PINF;
    end else begin
      cls_o = CLS_NORM;
    end
  end
endmodule

// File: rtl/isqrt_prescale.sv
module isqrt_prescale
  import isqrt_prep_pkg::*;
#(
  parameter int SMALL_EXP_MAX = 24,
  parameter int SCALE_POW     = 64
) (
  input  logic [FP_W-1:0] op_i,
  output logic [FP_W-1:0] op_o,
  output logic            small_o
);
  localparam int SUB_BASE = SCALE_POW + 1 - FRAC_W;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic [POS_W-1:0]  lead_pos;
  logic [FRAC_W-1:0] frac_norm;

  assign exp_f  = op_i[FP_W-2 -: EXP_W];
  assign frac_f = op_i[FRAC_W-1:0];

  always_comb begin
    lead_pos = '0;
    for (int b = 0; b < FRAC_W; b++) begin
      if (frac_f[b]) lead_pos = POS_W'(b);
    end
  end

  // Shifting by FRAC_W - p drops the implicit leading one off the top.
  assign frac_norm = frac_f << (FRAC_W - int'(lead_pos));

  always_comb begin
    small_o = (int'(exp_f) <= SMALL_EXP_MAX);
    op_o    = op_i;
    if (small_o) begin
      if (exp_f == '0)
        op_o = {op_i[FP_W-1], EXP_W'(int'(lead_pos) + SUB_BASE), frac_norm};
      else
        op_o = {op_i[FP_W-1], EXP_W'(int'(exp_f) + SCALE_POW), frac_f};
    end
  end
endmodule

// File: rtl/isqrt_seed_rom.sv
module isqrt_seed_rom
  import isqrt_prep_pkg::*;
(
  input  logic [SEED_IDX_W-1:0] idx_i,
  output logic [SEED_W-1:0]     seed_o
);
  localparam int ROW_BITS = 3;
  localparam int COL_BITS = SEED_IDX_W - ROW_BITS;
  localparam int ROW_W    = SEED_W << ROW_BITS;

  logic [ROW_W-1:0]    row_word;
  logic [COL_BITS-1:0] row_sel;
  logic [ROW_BITS-1:0] col_sel;

  assign row_sel = idx_i[SEED_IDX_W-1 -: COL_BITS];
  assign col_sel = idx_i[ROW_BITS-1:0];

  // Each row holds eight seeds, lowest index in the top byte.
  // Rows 0-7: odd unbiased exponent half; rows 8-15: even half.
  always_comb begin
    case (row_sel)
      4'd0:  row_word = 64'h6966_6361_5e5b_5957;
      4'd1:  row_word = 64'h5452_504d_4b49_4745;
      4'd2:  row_word = 64'h4341_3f3d_3b39_3736;
      4'd3:  row_word = 64'h3432_302f_2d2c_2a28;
      4'd4:  row_word = 64'h2725_2422_211f_1e1d;
      4'd5:  row_word = 64'h1b1a_1917_1615_1412;
      4'd6:  row_word = 64'h1110_0f0d_0c0b_0a09;
      4'd7:  row_word = 64'h0807_0605_0403_0201;
      4'd8:  row_word = 64'hfefa_f6f3_efeb_e8e4;
      4'd9:  row_word = 64'he1de_dbd7_d4d1_cecb;
      4'd10: row_word = 64'hc9c6_c3c0_bebb_b8b6;
      4'd11: row_word = 64'hb3b1_afac_aaa8_a5a3;
      4'd12: row_word = 64'ha19f_9d9b_9997_9593;
      4'd13: row_word = 64'h918f_8d8b_8987_8684;
      4'd14: row_word = 64'h8280_7f7d_7b7a_7877;
      default: row_word = 64'h7574_7271_6f6e_6c6b;
    endcase
  end

  assign seed_o = row_word[ROW_W-1 - SEED_W*int'(col_sel) -: SEED_W];
endmodule

// File: rtl/fp_isqrt_prep.sv
module fp_isqrt_prep
  import isqrt_prep_pkg::*;
#(
  parameter int          SMALL_EXP_MAX = 24,
  parameter int          SCALE_POW     = 64,
  parameter logic [7:0]  ADJUST_SMALL  = 8'hE0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [31:0] in_operand,
  output logic        out_valid,
  output logic [31:0] out_operand,
  output logic [31:0] out_result,
  output logic [7:0]  out_adjust,
  output logic        out_normal,
  output logic        out_invalid,
  output logic [7:0]  out_seed
);
  isqrt_cls_e        cls;
  logic              cls_invalid;
  logic [FP_W-1:0]   scaled_op;
  logic              is_small;
  logic [FP_W-1:0]   nxt_op;
  logic [FP_W-1:0]   nxt_res;
  logic [7:0]        nxt_adj;
  logic              nxt_norm;
  logic [SEED_IDX_W-1:0] seed_idx;
  logic [SEED_W-1:0] seed_val;

  isqrt_screen u_screen (
    .op_i      (in_operand),
    .cls_o     (cls),
    .invalid_o (cls_invalid)
  );

  isqrt_prescale #(
    .SMALL_EXP_MAX (SMALL_EXP_MAX),
    .SCALE_POW     (SCALE_POW)
  ) u_prescale (
    .op_i    (in_operand),
    .op_o    (scaled_op),
    .small_o (is_small)
  );

  always_comb begin
    nxt_op   = in_operand;
    nxt_res  = '0;
    nxt_adj  = '0;
    nxt_norm = 1'b0;
    case (cls)
      CLS_NAN, CLS_NEG: begin
        nxt_op  = WORD_NAN;
        nxt_res = WORD_NAN;
      end
      CLS_PINF: begin
        nxt_op  = WORD_PINF;
        nxt_res = WORD_PINF;
      end
      CLS_ZERO: nxt_res = WORD_ONE;
      default: begin
        nxt_op   = scaled_op;
        nxt_adj  = is_small ? ADJUST_SMALL : 8'h00;
        nxt_norm = 1'b1;
      end
    endcase
  end

  // Index: exponent parity on top, then the leading fraction bits.
  assign seed_idx = {nxt_op[FRAC_W], nxt_op[FRAC_W-1 -: FRAC_IDX_W]};

  isqrt_seed_rom u_seed (
    .idx_i  (seed_idx),
    .seed_o (seed_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_invalid <= 1'b0;
      out_operand <= '0;
      out_result  <= '0;
      out_adjust  <= '0;
      out_normal  <= 1'b0;
      out_seed    <= '0;
    end else begin
      out_valid   <= in_valid;
      out_invalid <= in_valid & cls_invalid;
      if (in_valid) begin
        out_operand <= nxt_op;
        out_result  <= nxt_res;
        out_adjust  <= nxt_adj;
        out_normal  <= nxt_norm;
        out_seed    <= seed_val;
      end
    end
  end
endmodule

// File: rtl/fp_isqrt_prep_checker.sv
module fp_isqrt_prep_checker #(
  parameter logic [7:0] ADJUST_SMALL = 8'hE0
) (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        out_valid,
  input logic [31:0] out_operand,
  input logic [31:0] out_result,
  input logic [7:0]  out_adjust,
  input logic        out_normal,
  input logic        out_invalid
);
  assert_valid_next_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_next_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_invalid && $stable(out_operand)));

  assert_invalid_with_valid_R2: assert property (@(posedge clk) disable iff (rst)
    out_invalid |-> out_valid);

  assert_invalid_gives_nan_R3: assert property (@(posedge clk) disable iff (rst)
    out_invalid |-> (out_operand == 32'hFFFF_FFFF && out_result == 32'hFFFF_FFFF));

  assert_normal_result_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_normal) |-> (out_result == 32'h0 && !out_invalid));

  assert_adjust_code_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_adjust == 8'h00 || (out_adjust == ADJUST_SMALL && out_normal)));
endmodule

bind fp_isqrt_prep fp_isqrt_prep_checker #(.ADJUST_SMALL(ADJUST_SMALL)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .out_valid   (out_valid),
  .out_operand (out_operand),
  .out_result  (out_result),
  .out_adjust  (out_adjust),
  .out_normal  (out_normal),
  .out_invalid (out_invalid)
);

// File: tb/tb_fp_isqrt_prep.sv
module tb_fp_isqrt_prep;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_operand = '0;
  logic        out_valid;
  logic [31:0] out_operand;
  logic [31:0] out_result;
  logic [7:0]  out_adjust;
  logic        out_normal;
  logic        out_invalid;
  logic [7:0]  out_seed;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  fp_isqrt_prep dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_operand(in_operand),
    .out_valid(out_valid), .out_operand(out_operand), .out_result(out_result),
    .out_adjust(out_adjust), .out_normal(out_normal), .out_invalid(out_invalid),
    .out_seed(out_seed)
  );

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Expected outputs derived from R1..R7.
  task automatic model(input logic [31:0] x, output logic [31:0] eop,
                       output logic [31:0] eres, output logic [7:0] eadj,
                       output logic enorm, output logic einv);
    int e = int'(x[30:23]);
    logic [22:0] f = x[22:0];
    eop = x; eres = '0; eadj = '0; enorm = 1'b0; einv = 1'b0;
    if (e == 255 && f != 0) begin
      eop = '1; eres = '1; einv = ~f[22];
    end else if (e == 0 && f == 0) begin
      eres = 32'h3F80_0000;
    end else if (x[31]) begin
      eop = '1; eres = '1; einv = 1'b1;
    end else if (e == 255) begin
      eop = 32'h7F80_0000; eres = 32'h7F80_0000;
    end else begin
      enorm = 1'b1;
      if (e <= 24) begin
        eadj = 8'hE0;
        if (e == 0) begin
          int p = 0;
          for (int b = 0; b < 23; b++) if (f[b]) p = b;
          eop = {1'b0, 8'(p + 42), 23'(f << (23 - p))};
        end else begin
          eop = {1'b0, 8'(e + 64), f};
        end
      end
    end
  endtask

  task automatic check_seed(logic [31:0] op, logic [7:0] seed);
    int  idx = int'({op[23], op[22:17]});
    real x, ref_v, d;
    if (idx < 64) x = 2.0 + (real'(idx) + 0.5) / 32.0;
    else          x = 1.0 + (real'(idx - 64) + 0.5) / 64.0;
    ref_v = 256.0 * (2.0 / $sqrt(x) - 1.0);
    d = real'(seed) - ref_v;
    n_chk++;
    if (d > 1.0 || d < -1.0) begin
      n_fail++;
      $display("FAIL R8 seed idx=%0d actual=%h expected~%f", idx, seed, ref_v);
    end
  endtask

  task automatic apply(logic [31:0] x, string req);
    logic [31:0] eop, eres;
    logic [7:0]  eadj;
    logic        enorm, einv;
    model(x, eop, eres, eadj, enorm, einv);
    @(negedge clk);
    in_valid = 1'b1; in_operand = x;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R9 valid"},   32'(out_valid), 32'd1);
    check({req, " operand"},    out_operand, eop);
    check({req, " result"},     out_result, eres);
    check({req, " adjust"},     32'(out_adjust), 32'(eadj));
    check({req, " normal"},     32'(out_normal), 32'(enorm));
    check({req, " R2 invalid"}, 32'(out_invalid), 32'(einv));
    check_seed(eop, out_seed);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] prev;
    repeat (3) @(negedge clk);
    check("reset R9 valid", 32'(out_valid), 32'd0);
    check("reset operand",  out_operand, 32'h0);
    check("reset invalid",  32'(out_invalid), 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // R1 / R2: NaN variants
    apply(32'h7FC0_0000, "R1 quiet NaN");
    apply(32'h7F80_0001, "R1 signaling NaN");
    apply(32'hFFC0_0001, "R1 negative quiet NaN");
    apply(32'hFFA0_0000, "R1 negative signaling NaN");
    // R9: hold after a pulse, invalid drops
    @(negedge clk);
    check("R9 idle valid",   32'(out_valid), 32'd0);
    check("R9 idle invalid", 32'(out_invalid), 32'd0);
    check("R9 idle hold",    out_operand, 32'hFFFF_FFFF);

    // R3: negative nonzero values
    apply(32'hBF80_0000, "R3 minus one");
    apply(32'hFF80_0000, "R3 minus inf");
    apply(32'h8000_0001, "R3 minus subnormal");
    // R4 / R5
    apply(32'h7F80_0000, "R4 plus inf");
    apply(32'h0000_0000, "R5 plus zero");
    apply(32'h8000_0000, "R5 minus zero");

    // R6: exponent boundary 24 / 25
    apply(32'h0C00_0000, "R6 exp24");
    check("R6 exp24 scaled", out_operand, 32'h2C00_0000);
    apply(32'h0C80_0000, "R6 exp25");
    check("R6 exp25 kept", out_operand, 32'h0C80_0000);
    apply(32'h0C7F_FFFF, "R6 exp24 full frac");

    // R6: sweep of exponent fields
    for (int e = 1; e <= 254; e++) begin
      apply({1'b0, 8'(e), 23'h000000}, "R6 sweep");
      apply({1'b0, 8'(e), 23'h7FFFFF}, "R6 sweep");
      apply({1'b0, 8'(e), 23'h2AAAAA}, "R6 sweep");
    end

    // R7: subnormals, every leading-one position
    apply(32'h0000_0001, "R7 p0");
    check("R7 p0 value", out_operand, 32'h1500_0000);
    apply(32'h0040_0000, "R7 p22");
    check("R7 p22 value", out_operand, 32'h2000_0000);
    for (int p = 0; p < 23; p++) begin
      apply({9'h0, 23'(1) << p}, "R7 single");
      apply({9'h0, (23'(1) << p) | ((23'(1) << p) - 23'(1))}, "R7 dense");
      apply({9'h0, (23'(1) << p) | 23'(p == 0 ? 0 : 1)}, "R7 sparse");
    end

    // R8: every seed index through unscaled operands
    prev = 8'h00;
    for (int i = 0; i < 128; i++) begin
      apply({1'b0, (i >= 64) ? 8'd127 : 8'd126, 6'(i), 17'h0AAAA}, "R8 index");
      if (i == 0)   check("R8 entry0",   32'(out_seed), 32'h69);
      if (i == 63)  check("R8 entry63",  32'(out_seed), 32'h01);
      if (i == 64)  check("R8 entry64",  32'(out_seed), 32'hFE);
      if (i == 127) check("R8 entry127", 32'(out_seed), 32'h6B);
      if (i != 0 && i != 64) begin
        n_chk++;
        if (out_seed > prev) begin
          n_fail++;
          $display("FAIL R8 rising at %0d actual=%h expected<=%h", i, out_seed, prev);
        end
      end
      prev = out_seed;
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule